// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and can move a word between them in either direction. Each direction owns a capture register with its own clock: the A-side register samples the A pins and the B-side register samples the B pins. When a bus is driven, a per-direction select decides whether it carries the live word from the opposite bus or the word held in the opposite side's register. A parameter makes the path inverting, so the driven bus receives the complement of the chosen source.

An active-low enable and a direction input decide which bus, if any, is driven. The bus pins are split into input, output and per-bit output-enable vectors, so the block synthesizes as plain logic and a chip-level pad ring or tri-state wrapper can sit around it. Capture ignores the enable and direction inputs, so a word can be stored while both buses are isolated.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst` low, the A-side register takes the value on `a_in`, whatever the values of `oe_n` and `dir`.
- R2: On every rising edge of `clk_ba` with `rst` low, the B-side register takes the value on `b_in`, whatever the values of `oe_n` and `dir`.
- R3: Reset is synchronous and active high, and each register sees it in its own clock domain: a rising edge of a register's clock with `rst` high clears that register to zero and leaves the other register alone.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are all zeros, and changes to `dir`, the selects and the bus inputs leave both stored words unchanged unless a capture clock rises.
- R5: With `oe_n` at 0 and `dir` at 0, `a_oe` is all ones and `b_oe` all zeros; `a_out` carries `b_in` when `sel_ba` is 0 and the B-side stored word when `sel_ba` is 1; `sel_ab` has no effect on the outputs.
- R6: With `oe_n` at 0 and `dir` at 1, `b_oe` is all ones and `a_oe` all zeros; `b_out` carries `a_in` when `sel_ab` is 0 and the A-side stored word when `sel_ab` is 1; `sel_ba` has no effect on the outputs.
- R7: `a_oe` and `b_oe` are never non-zero together, and each is either all ones or all zeros.
- R8: With `INVERT` set to 1, the driven bus carries the bitwise complement of the chosen source, live or stored, while the registers keep the true pin values.
- R9: Whenever a side's enable vector is zero, that side's output data vector is zero.
- R10: When a bus is driven and its own capture clock rises, the register stores the value present on that bus's pins, which is the driven value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, seen on each capture clock |
| clk_ab | input | 1 | Capture clock for the A-side register |
| clk_ba | input | 1 | Capture clock for the B-side register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| sel_ab | input | 1 | Source toward B: 0 live A pins, 1 stored A word |
| sel_ba | input | 1 | Source toward A: 0 live B pins, 1 stored B word |
| a_in | input | 8 | Value present on the A pins |
| b_in | input | 8 | Value present on the B pins |
| a_out | output | 8 | Data driven onto the A pins |
| a_oe | output | 8 | Per-bit drive enable for the A pins |
| b_out | output | 8 | Data driven onto the B pins |
| b_oe | output | 8 | Per-bit drive enable for the B pins |

## Verification
The bench stores words while both buses are isolated and reads them back later through the stored path; a design that gated capture with the enable would return the reset value instead. It flips the select of the direction that is not driven and expects no change, which catches a crossed select, and it resets one clock domain alone to catch a reset that clears both registers. A loopback case feeds the driven A value back to the A pins before an A capture, and an inverting instance checks that inversion lands on both the live and the stored paths while the stored word stays true.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    localparam int unsigned BXR_WIDTH_DEFAULT = 8;

    typedef enum logic {
        TOWARD_A = 1'b0,
        TOWARD_B = 1'b1
    } flow_e;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

    function automatic drive_t decode_drive(input logic oe_n, input flow_e flow);
        drive_t d;
        d.drive_a = !oe_n && (flow == TOWARD_A);
        d.drive_b = !oe_n && (flow == TOWARD_B);
        return d;
    endfunction

endpackage

// File: rtl/bxr_capture_reg.sv
module bxr_capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bxr_drive_ctrl.sv
module bxr_drive_ctrl
    import bxr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             oe_n,
    input  logic             dir,
    output logic             drv_a,
    output logic             drv_b,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_oe
);

    drive_t dec;
    flow_e  flow;

    always_comb begin
        flow  = flow_e'(dir);
        dec   = decode_drive(oe_n, flow);
        drv_a = dec.drive_a;
        drv_b = dec.drive_b;
        a_oe  = {WIDTH{dec.drive_a}};
        b_oe  = {WIDTH{dec.drive_b}};
    end

endmodule

// File: rtl/bxr_path_mux.sv
module bxr_path_mux
    import bxr_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter bit          INVERT = 1'b0
) (
    input  logic             sel,
    input  logic             en,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] dout
);

    src_e             src;
    logic [WIDTH-1:0] picked;
    logic [WIDTH-1:0] shaped;

    always_comb begin
        src    = src_e'(sel);
        picked = (src == SRC_HELD) ? held : live;
    end

    generate
        if (INVERT) begin : g_inv
            always_comb shaped = ~picked;
        end else begin : g_true
            always_comb shaped = picked;
        end
    endgenerate

    always_comb dout = en ? shaped : '0;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import bxr_pkg::*;
#(
    parameter int unsigned WIDTH  = BXR_WIDTH_DEFAULT,
    parameter bit          INVERT = 1'b0
) (
    input  logic             rst,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    logic [WIDTH-1:0] held_a;
    logic [WIDTH-1:0] held_b;
    logic             drv_a;
    logic             drv_b;

    // A pins are sampled by the A-to-B clock, B pins by the B-to-A clock.
    bxr_capture_reg #(.WIDTH(WIDTH)) u_cap_a (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (held_a)
    );

    bxr_capture_reg #(.WIDTH(WIDTH)) u_cap_b (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (held_b)
    );

    bxr_drive_ctrl #(.WIDTH(WIDTH)) u_drv (
        .oe_n  (oe_n),
        .dir   (dir),
        .drv_a (drv_a),
        .drv_b (drv_b),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    // Toward A: source is the B side.
    bxr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_to_a (
        .sel  (sel_ba),
        .en   (drv_a),
        .live (b_in),
        .held (held_b),
        .dout (a_out)
    );

    // Toward B: source is the A side.
    bxr_path_mux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_to_b (
        .sel  (sel_ab),
        .en   (drv_b),
        .live (a_in),
        .held (held_a),
        .dout (b_out)
    );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             rst,
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             oe_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe,
    input logic [WIDTH-1:0] held_a,
    input logic [WIDTH-1:0] held_b
);

    always_comb begin
        if (rst === 1'b0) begin
            // R7
            one_side_chk: assert (!((|a_oe) && (|b_oe)));
            // R7
            uniform_oe_chk: assert ((a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));
            // R4
            isolate_chk: assert (!(oe_n === 1'b1) || (a_oe == '0 && b_oe == '0));
            // R9
            quiet_out_chk: assert (((|a_oe) || a_out == '0) && ((|b_oe) || b_out == '0));
        end
    end

    // R1
    cap_a_chk: assert property (@(posedge clk_ab) disable iff (rst)
        !rst |=> held_a == $past(a_in));

    // R2
    cap_b_chk: assert property (@(posedge clk_ba) disable iff (rst)
        !rst |=> held_b == $past(b_in));

    // R3
    clr_a_chk: assert property (@(posedge clk_ab) rst |=> held_a == '0);

    // R3
    clr_b_chk: assert property (@(posedge clk_ba) rst |=> held_b == '0);

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .rst    (rst),
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .oe_n   (oe_n),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .held_a (held_a),
    .held_b (held_b)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_ab = 1'b0;
    logic       clk_ba = 1'b0;
    logic       oe_n = 1'b1;
    logic       dir = 1'b0;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;

    logic [7:0] a_out, a_oe, b_out, b_oe;
    logic [7:0] ia_out, ia_oe, ib_out, ib_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b0)) u0 (
        .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    bus_xcvr_reg #(.WIDTH(8), .INVERT(1'b1)) u1 (
        .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(ia_out), .a_oe(ia_oe), .b_out(ib_out), .b_oe(ib_oe)
    );

    // Fields: [37]oe_n [36]dir [35]sel_ab [34]sel_ba [33:26]a_in [25:18]b_in
    //         [17]exp A drive [16:9]exp a_out [8]exp B drive [7:0]exp b_out
    // Stored words during the table: A side 8'h3C, B side 8'hA5.
    localparam int NV = 8;
    localparam logic [37:0] TBL [0:NV-1] = '{
        {4'b1000, 8'h11, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00},
        {4'b1111, 8'h11, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00},
        {4'b0000, 8'h11, 8'h22, 1'b1, 8'h22, 1'b0, 8'h00},
        {4'b0001, 8'h11, 8'h22, 1'b1, 8'hA5, 1'b0, 8'h00},
        {4'b0100, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1, 8'h11},
        {4'b0110, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1, 8'h3C},
        {4'b0010, 8'hF0, 8'h0F, 1'b1, 8'h0F, 1'b0, 8'h00},
        {4'b0101, 8'hF0, 8'h0F, 1'b0, 8'h00, 1'b1, 8'hF0}
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_ab();
        #2 clk_ab = 1'b1;
        #3 clk_ab = 1'b0;
        #2;
    endtask

    task automatic pulse_ba();
        #2 clk_ba = 1'b1;
        #3 clk_ba = 1'b0;
        #2;
    endtask

    task automatic ctl(input logic o, input logic d, input logic sab, input logic sba);
        oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset both domains
        rst = 1'b1;
        pulse_ab(); pulse_ba();
        rst = 1'b0;
        #3;

        // R3: stored words read back as zero
        ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3", "a_out stored B after reset", a_out, 8'h00);
        ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3", "b_out stored A after reset", b_out, 8'h00);
        // R8: inverted stored zero
        check("R8", "inverting b_out of reset word", ib_out, 8'hFF);

        // R1/R2: load while isolated
        ctl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'h3C; pulse_ab();
        b_in = 8'hA5; pulse_ba();

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = TBL[i];
            a_in = v[33:26];
            b_in = v[25:18];
            ctl(v[37], v[36], v[35], v[34]);
            #1;
            // R4 R5 R6 R7 R9
            check("R5", $sformatf("vec%0d a_oe", i), a_oe, {8{v[17]}});
            check("R5", $sformatf("vec%0d a_out", i), a_out, v[16:9]);
            check("R6", $sformatf("vec%0d b_oe", i), b_oe, {8{v[8]}});
            check("R6", $sformatf("vec%0d b_out", i), b_out, v[7:0]);
            // R8: complement on driven side only
            check("R8", $sformatf("vec%0d inv a_out", i), ia_out, v[16:9] ^ {8{v[17]}});
            check("R8", $sformatf("vec%0d inv b_out", i), ib_out, v[7:0] ^ {8{v[8]}});
        end

        // R4: isolation with churn and no clocks keeps both words
        ctl(1'b1, 1'b1, 1'b1, 1'b1);
        a_in = 8'hEE; b_in = 8'hDD;
        ctl(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", "a_oe isolated", a_oe, 8'h00);
        check("R4", "b_oe isolated", b_oe, 8'h00);
        ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R4", "A word held", b_out, 8'h3C);
        ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R4", "B word held", a_out, 8'hA5);

        // R1: capture A while driving toward A; B word untouched
        a_in = 8'h77; pulse_ab();
        check("R1", "B word after A capture", a_out, 8'hA5);
        ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R1", "A word captured while enabled", b_out, 8'h77);

        // R2: capture B while driving toward B
        b_in = 8'hC3; pulse_ba();
        check("R2", "A word after B capture", b_out, 8'h77);
        ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R2", "B word captured while enabled", a_out, 8'hC3);

        // R3: reset seen only in the A domain
        rst = 1'b1; pulse_ab(); rst = 1'b0;
        ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R3", "A word cleared", b_out, 8'h00);
        ctl(1'b0, 1'b0, 1'b0, 1'b1);
        check("R3", "B word kept", a_out, 8'hC3);

        // R10: loopback of driven A pins into A capture
        b_in = 8'h66;
        ctl(1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", "driven A value", a_out, 8'h66);
        a_in = a_out;
        pulse_ab();
        a_in = 8'h00;
        ctl(1'b0, 1'b1, 1'b1, 1'b0);
        check("R10", "stored driven value", b_out, 8'h66);
        // R8: stored word is true, complement only at output
        check("R8", "inverting stored path", ib_out, 8'h99);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule